// File: doc/BRIEF.md
# Offset Register Port Controller

This block sits beside a FIFO and gives the FIFO's ordinary data buses a second use: loading and reading back the two programmable threshold offsets, one for the almost-empty flag and one for the almost-full flag. A load-select input chooses between the two uses. With load-select low, a write-enabled write-clock edge stores the input word into an offset register. A read-enabled read-clock edge puts an offset register onto the output bus. With load-select high, the same enables are passed on as FIFO write and read strobes. The offset width equals the FIFO address width. The data bus may be wider, and its extra bits are dropped on a load and returned as zero on a read-back.

Each clock domain has its own two-state pointer, `PTR_EMPTY` or `PTR_FULL`. The step transition `PTR_EMPTY -> PTR_FULL` is taken on an offset access in that domain, the wrap transition `PTR_FULL -> PTR_EMPTY` on the next one, and in every other cycle the pointer holds. A master reset returns both pointers to `PTR_EMPTY` and reloads the default offsets. A partial reset freezes all offset and FIFO access while it is low but leaves the pointers and offsets alone. Because the pointers only move on offset accesses, a programming or read-back sequence can be broken off for FIFO traffic and picked up again where it stopped. Two validity outputs tell the flag logic when each offset can be trusted after it has been reprogrammed.

Top module: `ofs_port_ctrl`

## Requirements
- R1: While `mrst_n` is low, `empty_ofs` equals DEF_EMPTY_OFS (127), `full_ofs` equals DEF_FULL_OFS (255), `q_out` is 0, `q_from_ofs` is 0, both `*_ofs_ok` outputs are 1, and both pointers are in `PTR_EMPTY`.
- R2: With `prst_n` high, `load_n` low and `wen_n` low, successive rising `wclk` edges store `d_in[AW-1:0]` into the empty offset, then the full offset, then the empty offset again, alternating.
- R3: With `prst_n` high, `load_n` low and `ren_n` low, successive rising `rclk` edges load `q_out` with the empty offset, then the full offset, then the empty offset again, and set `q_from_ofs` to 1. At all other `rclk` edges `q_out` holds its value.
- R4: The write pointer and the read pointer move independently of each other. A read-back returns the register chosen by the read pointer, whatever the write pointer holds.
- R5: While `prst_n` is low, no offset is written, `q_out` does not change, `fifo_wr_en` and `fifo_rd_en` are 0, and neither pointer moves.
- R6: With `load_n` high and `prst_n` high, `fifo_wr_en` equals the inverse of `wen_n` and `fifo_rd_en` equals the inverse of `ren_n`, and the offsets are not changed. Once load-select goes low again, offset access resumes at the register after the last one accessed.
- R7: A rising `rclk` edge with `fifo_rd_en` at 1 clears `q_from_ofs`, because the FIFO's word has replaced the read-back value. `q_out` itself is not changed.
- R8: Bits `d_in[DW-1:AW]` have no effect on the stored offset, and `q_out[DW-1:AW]` is always 0.
- R9: A write to the empty offset drops `full_ofs_ok` at that `wclk` edge. After the next write to the full offset, `full_ofs_ok` is still 0 one `wclk` edge later and is 1 two `wclk` edges later.
- R10: A write to the empty offset drops `empty_ofs_ok` at once. It returns to 1 after two further rising `rclk` edges.
- R11: With `load_n` low and the matching enable high, no offset is written, no read-back occurs, and the FIFO strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, active low |
| load_n | input | 1 | Load select, active low: steers accesses to the offset registers |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| d_in | input | DW | FIFO write data bus |
| empty_ofs | output | AW | Almost-empty threshold offset |
| full_ofs | output | AW | Almost-full threshold offset |
| q_out | output | DW | Read-back word for the output bus |
| q_from_ofs | output | 1 | 1 while the output bus shows the read-back word |
| fifo_wr_en | output | 1 | Write strobe to the FIFO storage |
| fifo_rd_en | output | 1 | Read strobe to the FIFO storage |
| empty_ofs_ok | output | 1 | Almost-empty offset is settled (read side) |
| full_ofs_ok | output | 1 | Almost-full offset is settled (write side) |

## Verification
The bench breaks off the programming sequence in three ways: with FIFO writes under load-select high, with load-select low and no enable, and with a partial reset. After each one it checks that the next load lands on the register that follows the last one written. A design that rewound its pointer, or advanced it on a break, would put the value in the wrong register. The bench also moves the write pointer while the read pointer stays put and then reads back, which catches a design that shares one pointer between the two domains. Finally it samples both validity outputs at the exact edge where each should rise, so a flag released one edge early or late, or never dropped, is reported. It also drives data with the upper bits set, which exposes any design that stores or returns those bits.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    // Which offset register a pointer selects next.
    typedef enum logic {
        PTR_EMPTY = 1'b0,
        PTR_FULL  = 1'b1
    } ofs_ptr_e;

endpackage

// File: rtl/ofs_ptr_fsm.sv
module ofs_ptr_fsm
    import ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_ptr_e ptr,
    output logic     sel_empty,
    output logic     sel_full
);

    ofs_ptr_e state_q;
    ofs_ptr_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: step (EMPTY->FULL), wrap (FULL->EMPTY), hold otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_EMPTY: if (step) state_d = PTR_FULL;
            PTR_FULL:  if (step) state_d = PTR_EMPTY;
            default:   state_d = PTR_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        sel_empty = 1'b0;
        sel_full  = 1'b0;
        unique case (state_q)
            PTR_EMPTY: sel_empty = 1'b1;
            PTR_FULL:  sel_full  = 1'b1;
            default:   sel_empty = 1'b1;
        endcase
    end

    assign ptr = state_q;

endmodule

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
    import ofs_pkg::*;
#(
    parameter int AW            = 14,
    parameter int DEF_EMPTY_OFS = 127,
    parameter int DEF_FULL_OFS  = 255,
    parameter int VALID_LAT     = 2
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          load_n,
    input  logic          wen_n,
    input  logic [AW-1:0] d_lo,
    output logic [AW-1:0] empty_ofs,
    output logic [AW-1:0] full_ofs,
    output logic          full_ok,
    output logic          empty_tog,
    output logic          fifo_wr_en
);

    localparam logic [AW-1:0] RST_EMPTY = AW'(DEF_EMPTY_OFS);
    localparam logic [AW-1:0] RST_FULL  = AW'(DEF_FULL_OFS);

    logic     wr_hit;
    logic     wr_empty;
    logic     wr_full;
    ofs_ptr_e wptr;
    logic     sel_e;
    logic     sel_f;

    assign wr_hit     = !load_n && !wen_n && prst_n;
    assign fifo_wr_en = load_n && !wen_n && prst_n;

    ofs_ptr_fsm u_wptr (
        .clk       (wclk),
        .rst_n     (mrst_n),
        .step      (wr_hit),
        .ptr       (wptr),
        .sel_empty (sel_e),
        .sel_full  (sel_f)
    );

    assign wr_empty = wr_hit && sel_e;
    assign wr_full  = wr_hit && sel_f;

    logic [AW-1:0] empty_q;
    logic [AW-1:0] full_q;

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            empty_q <= RST_EMPTY;
            full_q  <= RST_FULL;
        end else begin
            if (wr_empty) empty_q <= d_lo;
            if (wr_full)  full_q  <= d_lo;
        end
    end

    // Full offset goes stale on an empty-offset write; it is settled again
    // VALID_LAT edges after the full offset is written.
    logic                 f_stale_q;
    logic [VALID_LAT-1:0] f_stg_q;

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            f_stale_q <= 1'b0;
        end else if (wr_empty) begin
            f_stale_q <= 1'b1;
        end else if (wr_full) begin
            f_stale_q <= 1'b0;
        end
    end

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            f_stg_q[0] <= 1'b1;
        end else begin
            f_stg_q[0] <= !wr_empty && !f_stale_q;
        end
    end

    for (genvar gi = 1; gi < VALID_LAT; gi++) begin : g_fstg
        always_ff @(posedge wclk or negedge mrst_n) begin
            if (!mrst_n) begin
                f_stg_q[gi] <= 1'b1;
            end else begin
                f_stg_q[gi] <= !wr_empty && f_stg_q[gi-1];
            end
        end
    end

    // Toggle event announcing an empty-offset write to the read side.
    logic e_tog_q;

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            e_tog_q <= 1'b0;
        end else if (wr_empty) begin
            e_tog_q <= !e_tog_q;
        end
    end

    assign empty_ofs = empty_q;
    assign full_ofs  = full_q;
    assign full_ok   = f_stg_q[VALID_LAT-1];
    assign empty_tog = e_tog_q;

endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side
    import ofs_pkg::*;
#(
    parameter int AW        = 14,
    parameter int DW        = 18,
    parameter int VALID_LAT = 2
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          load_n,
    input  logic          ren_n,
    input  logic [AW-1:0] empty_ofs,
    input  logic [AW-1:0] full_ofs,
    input  logic          empty_tog,
    output logic [DW-1:0] q_out,
    output logic          q_from_ofs,
    output logic          empty_ok,
    output logic          fifo_rd_en
);

    logic     rd_hit;
    ofs_ptr_e rptr;
    logic     sel_e;
    logic     sel_f;

    assign rd_hit     = !load_n && !ren_n && prst_n;
    assign fifo_rd_en = load_n && !ren_n && prst_n;

    ofs_ptr_fsm u_rptr (
        .clk       (rclk),
        .rst_n     (mrst_n),
        .step      (rd_hit),
        .ptr       (rptr),
        .sel_empty (sel_e),
        .sel_full  (sel_f)
    );

    logic [AW-1:0] rb_sel;

    always_comb begin
        rb_sel = '0;
        if (sel_e) rb_sel = empty_ofs;
        if (sel_f) rb_sel = full_ofs;
    end

    logic [DW-1:0] q_q;
    logic          q_sel_q;

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            q_q <= '0;
        end else if (rd_hit) begin
            q_q <= DW'(rb_sel);
        end
    end

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            q_sel_q <= 1'b0;
        end else if (rd_hit) begin
            q_sel_q <= 1'b1;
        end else if (fifo_rd_en) begin
            q_sel_q <= 1'b0;
        end
    end

    // Synchronise the empty-write toggle; settled once the chain catches up.
    logic [VALID_LAT-1:0] sync_q;

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= empty_tog;
        end
    end

    for (genvar gi = 1; gi < VALID_LAT; gi++) begin : g_sync
        always_ff @(posedge rclk or negedge mrst_n) begin
            if (!mrst_n) begin
                sync_q[gi] <= 1'b0;
            end else begin
                sync_q[gi] <= sync_q[gi-1];
            end
        end
    end

    assign q_out      = q_q;
    assign q_from_ofs = q_sel_q;
    assign empty_ok   = (sync_q[VALID_LAT-1] == empty_tog);

endmodule

// File: rtl/ofs_port_ctrl.sv
module ofs_port_ctrl #(
    parameter int DW            = 18,
    parameter int AW            = 14,
    parameter int DEF_EMPTY_OFS = 127,
    parameter int DEF_FULL_OFS  = 255,
    parameter int VALID_LAT     = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          load_n,
    input  logic          wen_n,
    input  logic          ren_n,
    input  logic [DW-1:0] d_in,
    output logic [AW-1:0] empty_ofs,
    output logic [AW-1:0] full_ofs,
    output logic [DW-1:0] q_out,
    output logic          q_from_ofs,
    output logic          fifo_wr_en,
    output logic          fifo_rd_en,
    output logic          empty_ofs_ok,
    output logic          full_ofs_ok
);

    logic e_tog;

    // Data bits above the offset width are dropped on a load.
    if (DW > AW) begin : g_hi
        logic unused_hi_bits;
        assign unused_hi_bits = ^d_in[DW-1:AW];
    end

    ofs_wr_side #(
        .AW            (AW),
        .DEF_EMPTY_OFS (DEF_EMPTY_OFS),
        .DEF_FULL_OFS  (DEF_FULL_OFS),
        .VALID_LAT     (VALID_LAT)
    ) u_wr (
        .wclk       (wclk),
        .mrst_n     (mrst_n),
        .prst_n     (prst_n),
        .load_n     (load_n),
        .wen_n      (wen_n),
        .d_lo       (d_in[AW-1:0]),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs),
        .full_ok    (full_ofs_ok),
        .empty_tog  (e_tog),
        .fifo_wr_en (fifo_wr_en)
    );

    ofs_rd_side #(
        .AW        (AW),
        .DW        (DW),
        .VALID_LAT (VALID_LAT)
    ) u_rd (
        .rclk       (rclk),
        .mrst_n     (mrst_n),
        .prst_n     (prst_n),
        .load_n     (load_n),
        .ren_n      (ren_n),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs),
        .empty_tog  (e_tog),
        .q_out      (q_out),
        .q_from_ofs (q_from_ofs),
        .empty_ok   (empty_ofs_ok),
        .fifo_rd_en (fifo_rd_en)
    );

endmodule

// File: rtl/ofs_port_ctrl_chk.sv
module ofs_port_ctrl_chk #(
    parameter int DW = 18,
    parameter int AW = 14
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          load_n,
    input logic          wen_n,
    input logic          ren_n,
    input logic [AW-1:0] empty_ofs,
    input logic [AW-1:0] full_ofs,
    input logic [DW-1:0] q_out,
    input logic          q_from_ofs,
    input logic          fifo_rd_en,
    input logic          full_ofs_ok
);

    // R5 R6 R11: without an offset write request both offsets hold
    a_r6_offsets_hold: assert property (@(posedge wclk) disable iff (!mrst_n)
        !(!load_n && !wen_n && prst_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R2: one offset write touches at most one register
    a_r2_one_target: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!load_n && !wen_n && prst_n) |=> ($stable(empty_ofs) || $stable(full_ofs)));

    // R9: a new empty offset means the full offset is not yet settled
    a_r9_full_stale: assert property (@(posedge wclk) disable iff (!mrst_n)
        !$stable(empty_ofs) |-> !full_ofs_ok);

    // R3 R5 R11: output word moves only on a read-back
    a_r3_q_hold: assert property (@(posedge rclk) disable iff (!mrst_n)
        !(!load_n && !ren_n && prst_n) |=> $stable(q_out));

    // R3: a read-back puts the offset on the bus
    a_r3_sel_set: assert property (@(posedge rclk) disable iff (!mrst_n)
        (!load_n && !ren_n && prst_n) |=> q_from_ofs);

    // R7: a FIFO read replaces the read-back word
    a_r7_sel_drop: assert property (@(posedge rclk) disable iff (!mrst_n)
        fifo_rd_en |=> !q_from_ofs);

    if (DW > AW) begin : g_hi
        // R8: upper output bits stay zero
        a_r8_upper_zero: assert property (@(posedge rclk) disable iff (!mrst_n)
            q_out[DW-1:AW] == '0);
    end

endmodule

bind ofs_port_ctrl ofs_port_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
    .wclk        (wclk),
    .rclk        (rclk),
    .mrst_n      (mrst_n),
    .prst_n      (prst_n),
    .load_n      (load_n),
    .wen_n       (wen_n),
    .ren_n       (ren_n),
    .empty_ofs   (empty_ofs),
    .full_ofs    (full_ofs),
    .q_out       (q_out),
    .q_from_ofs  (q_from_ofs),
    .fifo_rd_en  (fifo_rd_en),
    .full_ofs_ok (full_ofs_ok)
);

// File: tb/test_ofs_port_ctrl.sv
module test_ofs_port_ctrl;

    localparam int DW = 18;
    localparam int AW = 14;
    localparam int DEF_E = 127;
    localparam int DEF_F = 255;
    localparam logic [DW-1:0] MASK = DW'((1 << AW) - 1);

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst_n, prst_n, load_n, wen_n, ren_n;
    logic [DW-1:0] d_in;
    logic [AW-1:0] empty_ofs, full_ofs;
    logic [DW-1:0] q_out;
    logic          q_from_ofs, fifo_wr_en, fifo_rd_en, empty_ofs_ok, full_ofs_ok;

    ofs_port_ctrl #(
        .DW(DW), .AW(AW), .DEF_EMPTY_OFS(DEF_E), .DEF_FULL_OFS(DEF_F), .VALID_LAT(2)
    ) i_ofs_port_ctrl (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .load_n(load_n), .wen_n(wen_n), .ren_n(ren_n), .d_in(d_in),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .q_out(q_out),
        .q_from_ofs(q_from_ofs), .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en),
        .empty_ofs_ok(empty_ofs_ok), .full_ofs_ok(full_ofs_ok)
    );

    // 50 MHz on both sides, read clock lagging by 7 ns
    always #10 wclk = ~wclk;
    initial begin
        #7;
        forever #10 rclk = ~rclk;
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model from the requirements
    logic [AW-1:0] m_e, m_f;
    bit            m_wp, m_rp;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    task automatic model_reset();
        m_e  = AW'(DEF_E);
        m_f  = AW'(DEF_F);
        m_wp = 1'b0;
        m_rp = 1'b0;
    endtask

    task automatic chk_ofs(input string req);
        chk(empty_ofs == m_e && full_ofs == m_f, req,
            {2'b0, empty_ofs, full_ofs}, {2'b0, m_e, m_f});
    endtask

    task automatic wr_ofs(input logic [DW-1:0] d);
        @(negedge wclk);
        load_n = 1'b0; wen_n = 1'b0; d_in = d;
        @(negedge wclk);
        load_n = 1'b1; wen_n = 1'b1;
        if (!m_wp) m_e = AW'(d & MASK);
        else       m_f = AW'(d & MASK);
        m_wp = !m_wp;
    endtask

    task automatic rd_ofs(input string req);
        @(negedge rclk);
        load_n = 1'b0; ren_n = 1'b0;
        exp_q.push_back(m_rp ? DW'(m_f) : DW'(m_e));
        tag_q.push_back(req);
        m_rp = !m_rp;
        @(negedge rclk);
        load_n = 1'b1; ren_n = 1'b1;
    endtask

    // Monitor: note read-back edges, compare half a cycle later
    bit rb_hit = 1'b0;
    always @(posedge rclk) rb_hit <= !load_n && !ren_n && prst_n && mrst_n;

    always @(negedge rclk) begin
        if (rb_hit && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(q_out == e, t, 32'(q_out), 32'(e));
            chk(q_from_ofs == 1'b1, {t, " R3 sel"}, 32'(q_from_ofs), 32'd1);
        end
    end

    logic [DW-1:0] q_keep;

    initial begin
        mrst_n = 1'b0; prst_n = 1'b1; load_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
        d_in = '0;
        model_reset();
        repeat (3) @(negedge wclk);
        // R1: reset state
        chk_ofs("R1 offsets");
        chk(q_out == '0 && q_from_ofs == 1'b0, "R1 output bus", 32'(q_out), 0);
        chk(empty_ofs_ok && full_ofs_ok, "R1 ok flags", {empty_ofs_ok, full_ofs_ok}, 3);
        chk(!fifo_wr_en && !fifo_rd_en, "R1 strobes", {fifo_wr_en, fifo_rd_en}, 0);
        mrst_n = 1'b1;
        repeat (2) @(negedge wclk);

        // R2 R8 R10 R9: first load goes to empty, upper bits dropped
        wr_ofs(18'h3_1234);
        chk_ofs("R2 R8 first load");
        chk(!empty_ofs_ok, "R10 empty stale", 32'(empty_ofs_ok), 0);
        chk(!full_ofs_ok, "R9 full stale after empty write", 32'(full_ofs_ok), 0);
        @(negedge wclk);
        chk(empty_ofs_ok, "R10 empty settled after two rclk", 32'(empty_ofs_ok), 1);
        wr_ofs(18'h2_0ABC);
        chk_ofs("R2 second load to full");
        chk(!full_ofs_ok, "R9 full edge0", 32'(full_ofs_ok), 0);
        @(negedge wclk);
        chk(!full_ofs_ok, "R9 full edge1", 32'(full_ofs_ok), 0);
        @(negedge wclk);
        chk(full_ofs_ok, "R9 full edge2", 32'(full_ofs_ok), 1);
        wr_ofs(18'h0_0055);
        chk_ofs("R2 third load wraps to empty");

        // R3 R8: read-back sequence empty, full, empty
        rd_ofs("R3 R8 rb0");
        rd_ofs("R3 rb1");
        rd_ofs("R3 rb2");

        // R7 R6: FIFO read clears read-back select, keeps q_out
        q_keep = q_out;
        @(negedge rclk);
        ren_n = 1'b0;
        #1 chk(fifo_rd_en, "R6 rd strobe", 32'(fifo_rd_en), 1);
        @(negedge rclk);
        ren_n = 1'b1;
        chk(!q_from_ofs, "R7 sel cleared", 32'(q_from_ofs), 0);
        chk(q_out == q_keep, "R7 q kept", 32'(q_out), 32'(q_keep));

        // R4: write pointer moves alone, read pointer still at full
        wr_ofs(18'h1_3FFF);
        chk_ofs("R4 load to full");
        rd_ofs("R4 rb full");
        rd_ofs("R4 rb empty");

        // R6: FIFO writes under load high, then resume at empty
        @(negedge wclk);
        wen_n = 1'b0; d_in = 18'h0_1111;
        #1 chk(fifo_wr_en, "R6 wr strobe", 32'(fifo_wr_en), 1);
        @(negedge wclk);
        wen_n = 1'b1;
        chk_ofs("R6 offsets untouched");
        wr_ofs(18'h0_0222);
        chk_ofs("R6 resume at empty");

        // R11: load low with no enable does nothing
        @(negedge wclk);
        load_n = 1'b0; d_in = 18'h0_0777;
        #1 chk(!fifo_wr_en && !fifo_rd_en, "R11 strobes", {fifo_wr_en, fifo_rd_en}, 0);
        repeat (2) @(negedge wclk);
        load_n = 1'b1;
        chk_ofs("R11 offsets untouched");
        wr_ofs(18'h0_0333);
        chk_ofs("R11 resume at full");

        // R5: partial reset blocks access and keeps pointers
        @(negedge wclk);
        prst_n = 1'b0; load_n = 1'b0; wen_n = 1'b0; d_in = 18'h0_0999;
        #1 chk(!fifo_wr_en, "R5 wr strobe", 32'(fifo_wr_en), 0);
        @(negedge wclk);
        wen_n = 1'b1;
        chk_ofs("R5 offsets untouched");
        q_keep = q_out;
        @(negedge rclk);
        ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1; load_n = 1'b1;
        chk(q_out == q_keep, "R5 q kept", 32'(q_out), 32'(q_keep));
        @(negedge wclk);
        prst_n = 1'b1;
        wr_ofs(18'h0_0444);
        chk_ofs("R5 write pointer kept");
        rd_ofs("R5 read pointer kept");

        // R1: master reset mid-run returns pointers to empty
        @(negedge wclk);
        mrst_n = 1'b0;
        #1 model_reset();
        chk_ofs("R1 mid-run reset");
        @(negedge wclk);
        mrst_n = 1'b1;
        wr_ofs(18'h0_0666);
        chk_ofs("R1 write pointer at empty");
        rd_ofs("R1 read pointer at empty");
        repeat (3) @(negedge rclk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge wclk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule